// File: doc/BRIEF.md
# Quasi-Bidirectional Port Bit Array

This block models an eight-bit general-purpose I/O port of a small microcontroller at the register-transfer level. Each bit has an output latch, a path that samples the pad, and three drive-enable flags: a pull-down, a strong pull-up and a weak pull-up. The pad electronics outside the block turn these flags into voltages. A parameter selects one of three port variants. The first is an open-drain port whose pins an internal address/data bus can take over. The second is a quasi-bidirectional port that can carry the upper address byte. The third is a quasi-bidirectional port in which every bit may carry a peripheral's output.

The CPU sees two read views. The latch view returns the stored output latch; read-modify-write instructions use it. The pin view returns the synchronised pad values; plain reads use it. The two views differ when an external load holds a pin away from its latch value. Writes come either as a whole byte or as a single bit selected by index. A two-flop synchroniser feeds both the pin view and the inputs handed to peripherals.

Top module: `qbPort`

## Requirements
- R1: During reset and after it is released, every latch bit is 1. The synchronised pin view also resets to all ones.
- R2: A byte write loads all eight latch bits, visible on the latch view one clock later. If a byte write and a bit write arrive in the same cycle, the byte write wins.
- R3: A bit write sets latch bit `bitSel` (0 is the least significant bit) to `bitData` one clock later. The other seven bits stay unchanged.
- R4: The latch view always shows the stored latch, whatever the pins carry. When a load holds a pin low under a latch bit of 1, the latch view reads 1 and the pin view reads 0.
- R5: A change on `pinIn` reaches `pinQ` and `altIn` exactly two clock edges later, and is not visible after only one.
- R6: Open-drain variant with `overrideEn` low: a latch bit of 1 enables no driver. A latch bit of 0 enables only the pull-down.
- R7: Open-drain variant with `overrideEn` high: each bit is push-pull from `overrideData`. A 1 enables only the strong pull-up, and a 0 enables only the pull-down.
- R8: Quasi-bidirectional variants in normal operation: a latch bit of 1 enables only the weak pull-up. A latch bit of 0 enables only the pull-down.
- R9: Address-byte variant with `overrideEn` high: each bit drives `overrideData` with the strong pull-up (for 1) or the pull-down (for 0). The latch keeps its value.
- R10: Alternate-function variant: the driven value of each bit is its latch bit ANDed with its `altOut` bit, using the quasi-bidirectional drive of R8. A bit whose latch is 0 pulls down whatever `altOut` carries, and `overrideEn` has no effect.
- R11: On no bit is the pull-down enabled together with either pull-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrByte | input | 1 | Whole-byte latch write strobe |
| wrData | input | 8 | Byte written to the latch |
| wrBit | input | 1 | Single-bit latch write strobe |
| bitSel | input | 3 | Index of the bit written by `wrBit` |
| bitData | input | 1 | Value written by `wrBit` |
| overrideEn | input | 1 | Address/data (or address-byte) takeover of the pins |
| overrideData | input | 8 | Value driven during takeover |
| altOut | input | 8 | Per-bit peripheral outputs (alternate-function variant) |
| pinIn | input | 8 | Sampled pad levels |
| latchQ | output | 8 | Latch view for read-modify-write |
| pinQ | output | 8 | Synchronised pin view for plain reads |
| altIn | output | 8 | Synchronised pin levels for peripherals |
| pullDown | output | 8 | Pull-down enable per bit |
| pullUpStrong | output | 8 | Strong pull-up enable per bit |
| pullUpWeak | output | 8 | Weak pull-up enable per bit |

## Verification
On every cycle, the assertions check that no bit has a pull-down and a pull-up enabled together. They also check that latch bits not addressed by a write hold their value, that a takeover leaves the latch alone, and that the pin view trails the pads by exactly two edges. They check as well that a floating open-drain bit enables nothing and that a zero latch forces a pull-down on the alternate-function variant. The exact drive pattern for each latch, alternate and override value can only be shown by the bench's sweeps, as can the byte-over-bit priority. So can the latch-versus-pin read under a load that holds a pin low.

// File: rtl/qbPortPkg.sv
package qbPortPkg;
  localparam int unsigned PORT_W = 8;
  localparam int unsigned SEL_W  = $clog2(PORT_W);

  typedef enum logic [1:0] {
    FLAV_OPEN_DRAIN = 2'd0,
    FLAV_QUASI_ADDR = 2'd1,
    FLAV_QUASI_ALT  = 2'd2
  } flavourT;

  // Write strobes from the control decoder to the datapath
  typedef struct packed {
    logic [PORT_W-1:0] wrMask;
    logic [PORT_W-1:0] wrVal;
  } latchStrobeT;
endpackage

// File: rtl/portWriteCtrl.sv
module portWriteCtrl
  import qbPortPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrByte,
  input  logic [PORT_W-1:0] wrData,
  input  logic             wrBit,
  input  logic [SEL_W-1:0] bitSel,
  input  logic             bitData,
  output latchStrobeT      strb
);
  localparam int unsigned W = PORT_W;

  logic [W-1:0] bitOneHot;

  always_comb begin
    bitOneHot = '0;
    bitOneHot[bitSel] = 1'b1;
  end

  always_comb begin
    if (wrByte) begin
      strb.wrMask = '1;
      strb.wrVal  = wrData;
    end else if (wrBit) begin
      strb.wrMask = bitOneHot;
      strb.wrVal  = {W{bitData}};
    end else begin
      strb.wrMask = '0;
      strb.wrVal  = '0;
    end
  end

  // R3: a lone bit write touches exactly one latch bit
  p_single_bit_mask_r3: assert property (@(posedge clk) disable iff (!rstN)
    (wrBit && !wrByte) |-> ($countones(strb.wrMask) == 1));

  // R2: a byte write reaches every bit, whatever the bit strobe does
  p_byte_full_mask_r2: assert property (@(posedge clk) disable iff (!rstN)
    wrByte |-> (&strb.wrMask && strb.wrVal == wrData));

endmodule

// File: rtl/portDatapath.sv
module portDatapath
  import qbPortPkg::*;
#(
  parameter flavourT     FLAVOUR     = FLAV_QUASI_ALT,
  parameter int unsigned SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  latchStrobeT       strb,
  input  logic              overrideEn,
  input  logic [PORT_W-1:0] overrideData,
  input  logic [PORT_W-1:0] altOut,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] latchQ,
  output logic [PORT_W-1:0] pinQ,
  output logic [PORT_W-1:0] altIn,
  output logic [PORT_W-1:0] pullDown,
  output logic [PORT_W-1:0] pullUpStrong,
  output logic [PORT_W-1:0] pullUpWeak
);
  localparam int unsigned W = PORT_W;

  logic [W-1:0] latchReg;
  logic [W-1:0] syncReg [SYNC_STAGES];
  logic         unusedInputs;

  // Not every variant consumes every input
  assign unusedInputs = ^{overrideEn, overrideData, altOut};

  // Output latch, set high on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) latchReg <= '1;
    else       latchReg <= (latchReg & ~strb.wrMask) | (strb.wrVal & strb.wrMask);
  end

  // Pin synchroniser chain
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[s] <= '1;
        else       syncReg[s] <= pinIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncReg[s] <= '1;
        else       syncReg[s] <= syncReg[s-1];
      end
    end
  end

  assign latchQ = latchReg;
  assign pinQ   = syncReg[SYNC_STAGES-1];
  assign altIn  = syncReg[SYNC_STAGES-1];

  // Drive-enable generation, one variant per flavour
  if (FLAVOUR == FLAV_OPEN_DRAIN) begin : g_od
    always_comb begin
      if (overrideEn) begin
        pullUpStrong = overrideData;
        pullDown     = ~overrideData;
        pullUpWeak   = '0;
      end else begin
        pullUpStrong = '0;
        pullUpWeak   = '0;
        pullDown     = ~latchReg;
      end
    end

    // R6: a released open-drain bit floats
    p_od_float_r6: assert property (@(posedge clk) disable iff (!rstN)
      !overrideEn |-> (((pullDown | pullUpStrong | pullUpWeak) & latchQ) == '0));
  end else if (FLAVOUR == FLAV_QUASI_ADDR) begin : g_addr
    always_comb begin
      if (overrideEn) begin
        pullUpStrong = overrideData;
        pullDown     = ~overrideData;
        pullUpWeak   = '0;
      end else begin
        pullUpStrong = '0;
        pullUpWeak   = latchReg;
        pullDown     = ~latchReg;
      end
    end
  end else begin : g_alt
    logic [W-1:0] effOut;
    assign effOut = latchReg & altOut;
    always_comb begin
      pullUpStrong = '0;
      pullUpWeak   = effOut;
      pullDown     = ~effOut;
    end

    // R10: a zero latch bit pulls down regardless of the peripheral
    p_alt_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
      ((~latchQ & ~pullDown) == '0));
  end

  // R11: no bit fights itself
  p_no_contention_r11: assert property (@(posedge clk) disable iff (!rstN)
    ((pullDown & (pullUpStrong | pullUpWeak)) == '0));

  // R3: bits outside the write mask keep their value
  p_unmasked_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((latchReg & ~$past(strb.wrMask)) == ($past(latchReg) & ~$past(strb.wrMask))));

  // R9: a takeover with no write leaves the latch alone
  p_override_keeps_latch_r9: assert property (@(posedge clk) disable iff (!rstN)
    (overrideEn && strb.wrMask == '0) |=> $stable(latchReg));

  // R5: pin view trails the pad by exactly two edges once settled
  logic [1:0] settleCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                settleCnt <= '0;
    else if (settleCnt != 2'd3) settleCnt <= settleCnt + 2'd1;
  end

  if (SYNC_STAGES == 2) begin : g_lat_chk
    p_sync_latency_r5: assert property (@(posedge clk) disable iff (!rstN)
      settleCnt[1] |-> (pinQ == $past(pinIn, 2)));
  end

endmodule

// File: rtl/qbPort.sv
module qbPort
  import qbPortPkg::*;
#(
  parameter flavourT     FLAVOUR     = FLAV_QUASI_ALT,
  parameter int unsigned SYNC_STAGES = 2
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrByte,
  input  logic [PORT_W-1:0] wrData,
  input  logic              wrBit,
  input  logic [SEL_W-1:0]  bitSel,
  input  logic              bitData,
  input  logic              overrideEn,
  input  logic [PORT_W-1:0] overrideData,
  input  logic [PORT_W-1:0] altOut,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] latchQ,
  output logic [PORT_W-1:0] pinQ,
  output logic [PORT_W-1:0] altIn,
  output logic [PORT_W-1:0] pullDown,
  output logic [PORT_W-1:0] pullUpStrong,
  output logic [PORT_W-1:0] pullUpWeak
);
  latchStrobeT strb;

  portWriteCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrByte  (wrByte),
    .wrData  (wrData),
    .wrBit   (wrBit),
    .bitSel  (bitSel),
    .bitData (bitData),
    .strb    (strb)
  );

  portDatapath #(
    .FLAVOUR     (FLAVOUR),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .overrideEn   (overrideEn),
    .overrideData (overrideData),
    .altOut       (altOut),
    .pinIn        (pinIn),
    .latchQ       (latchQ),
    .pinQ         (pinQ),
    .altIn        (altIn),
    .pullDown     (pullDown),
    .pullUpStrong (pullUpStrong),
    .pullUpWeak   (pullUpWeak)
  );
endmodule

// File: tb/tb_qbPort.sv
module tb_qbPort;
  import qbPortPkg::*;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrByte = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrBit = 1'b0;
  logic [2:0] bitSel = '0;
  logic       bitData = 1'b0;
  logic       overrideEn = 1'b0;
  logic [7:0] overrideData = '0;
  logic [7:0] altOut = 8'hFF;
  logic [7:0] pinIn = 8'hFF;

  logic [7:0] aLatch, aPin, aAltIn, aPd, aPs, aPw;
  logic [7:0] oLatch, oPin, oAltIn, oPd, oPs, oPw;
  logic [7:0] hLatch, hPin, hAltIn, hPd, hPs, hPw;

  int vectors = 0;
  int fails = 0;

  always #2 clk = ~clk;

  qbPort #(.FLAVOUR(FLAV_QUASI_ALT)) dut (
    .clk(clk), .rstN(rstN), .wrByte(wrByte), .wrData(wrData), .wrBit(wrBit),
    .bitSel(bitSel), .bitData(bitData), .overrideEn(overrideEn),
    .overrideData(overrideData), .altOut(altOut), .pinIn(pinIn),
    .latchQ(aLatch), .pinQ(aPin), .altIn(aAltIn), .pullDown(aPd),
    .pullUpStrong(aPs), .pullUpWeak(aPw));

  qbPort #(.FLAVOUR(FLAV_OPEN_DRAIN)) dutOd (
    .clk(clk), .rstN(rstN), .wrByte(wrByte), .wrData(wrData), .wrBit(wrBit),
    .bitSel(bitSel), .bitData(bitData), .overrideEn(overrideEn),
    .overrideData(overrideData), .altOut(altOut), .pinIn(pinIn),
    .latchQ(oLatch), .pinQ(oPin), .altIn(oAltIn), .pullDown(oPd),
    .pullUpStrong(oPs), .pullUpWeak(oPw));

  qbPort #(.FLAVOUR(FLAV_QUASI_ADDR)) dutHi (
    .clk(clk), .rstN(rstN), .wrByte(wrByte), .wrData(wrData), .wrBit(wrBit),
    .bitSel(bitSel), .bitData(bitData), .overrideEn(overrideEn),
    .overrideData(overrideData), .altOut(altOut), .pinIn(pinIn),
    .latchQ(hLatch), .pinQ(hPin), .altIn(hAltIn), .pullDown(hPd),
    .pullUpStrong(hPs), .pullUpWeak(hPw));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  task automatic writeByte(input logic [7:0] v);
    @(negedge clk);
    wrByte = 1'b1; wrData = v;
    @(negedge clk);
    wrByte = 1'b0;
  endtask

  task automatic writeBit(input logic [2:0] idx, input logic val);
    @(negedge clk);
    wrBit = 1'b1; bitSel = idx; bitData = val;
    @(negedge clk);
    wrBit = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    finishRun();
  end

  initial begin
    logic [7:0] expL;
    logic [7:0] rd;
    repeat (3) @(negedge clk);
    check("R1 latch during reset", aLatch, 8'hFF);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 alt latch", aLatch, 8'hFF);
    check("R1 od latch", oLatch, 8'hFF);
    check("R1 hi latch", hLatch, 8'hFF);
    check("R1 pin view", aPin, 8'hFF);
    check("R6 od float after reset", oPd | oPs | oPw, 8'h00);

    // Sweep every latch value on all variants
    for (int i = 0; i < 256; i++) begin
      logic [7:0] v;
      logic [7:0] a;
      v = 8'(i);
      a = 8'(i * 37) ^ 8'h5A;
      altOut = a;
      writeByte(v);
      check("R2 alt latch", aLatch, v);
      check("R2 od latch", oLatch, v);
      check("R2 hi latch", hLatch, v);
      check("R6 od pulldown", oPd, ~v);
      check("R6 od pullups", oPs | oPw, 8'h00);
      check("R8 hi weak", hPw, v);
      check("R8 hi pulldown", hPd, ~v);
      check("R8 hi strong", hPs, 8'h00);
      check("R10 alt weak", aPw, v & a);
      check("R10 alt pulldown", aPd, ~(v & a));
      check("R11 alt contention", aPd & (aPs | aPw), 8'h00);
    end
    altOut = 8'hFF;

    // Single-bit writes over every index and value
    writeByte(8'hA5);
    expL = 8'hA5;
    for (int i = 0; i < 8; i++) begin
      for (int b = 0; b < 2; b++) begin
        writeBit(3'(i), 1'(b));
        expL = (expL & ~(8'h01 << i)) | (8'(b) << i);
        check("R3 bit write", aLatch, expL);
      end
    end

    // Byte write wins over a simultaneous bit write
    @(negedge clk);
    wrByte = 1'b1; wrData = 8'h3C; wrBit = 1'b1; bitSel = 3'd0; bitData = 1'b1;
    @(negedge clk);
    wrByte = 1'b0; wrBit = 1'b0;
    check("R2 byte beats bit", aLatch, 8'h3C);

    // Synchroniser latency
    writeByte(8'hFF);
    @(negedge clk);
    pinIn = 8'h3C;
    @(negedge clk);
    check("R5 one edge hidden", aPin, 8'hFF);
    @(negedge clk);
    check("R5 two edges pinQ", aPin, 8'h3C);
    check("R5 two edges altIn", aAltIn, 8'h3C);

    // Load holding bit 1 low under a latch of ones
    pinIn = 8'hFD;
    repeat (2) @(negedge clk);
    check("R4 latch view", aLatch, 8'hFF);
    check("R4 pin view", aPin, 8'hFD);
    rd = aLatch;
    writeByte(rd | 8'h00);
    check("R4 rmw keeps latch", aLatch, 8'hFF);
    pinIn = 8'hFF;

    // Pin takeover sweep
    writeByte(8'h96);
    overrideEn = 1'b1;
    for (int i = 0; i < 256; i++) begin
      logic [7:0] d;
      d = 8'(i);
      @(negedge clk);
      overrideData = d;
      @(negedge clk);
      check("R7 od strong", oPs, d);
      check("R7 od pulldown", oPd, ~d);
      check("R7 od weak", oPw, 8'h00);
      check("R9 hi strong", hPs, d);
      check("R9 hi pulldown", hPd, ~d);
      check("R9 hi latch kept", hLatch, 8'h96);
      check("R10 alt ignores override", aPw, 8'h96);
    end
    @(negedge clk);
    overrideEn = 1'b0;
    @(negedge clk);
    check("R6 od back to latch", oPd, 8'h69);
    check("R8 hi back to latch", hPw, 8'h96);

    finishRun();
  end
endmodule